// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Logic

This block holds the interrupt status and interrupt enable registers of a USB host controller and raises one interrupt request toward the host bus. Other parts of the controller send it single-cycle event pulses: root hub change, start of frame, scheduling overrun and system error. They also send the device resume level, a flag for host-driven resume and the running 16-bit frame number. The block turns these into sticky status bits. It also counts scheduling overruns in a small wrapping counter and asserts a halt output while an unrecoverable error is pending.

Software reaches both registers through a command-code port. Bit 7 of the code selects a write and the low seven bits select the register. Status is read at code 03h, and writing ones at 83h clears those status bits. The enable register is read at 04h or 05h. Writing ones at 84h sets enable bits, and writing ones at 85h clears them. The command port uses a valid/ready handshake. `cmd_ready` is held high, so the block never applies back-pressure, and every beat with `cmd_valid` high is taken in that cycle. Read data is combinational from `cmd_code` and is valid in the same cycle as the read beat.

Top module: `usb_hc_irq_regs`

## Requirements
- R1: After reset, status reads 0, enable reads 0, `irq` and `halt` are low and `ovr_count` is 0.
- R2: A pulse on `ev_rhsc`, `ev_sys_err`, `ev_sof` or `ev_sched_ovr` sets status bit 6, 4, 2 or 0 in turn. The bit is set from the next clock edge and is read at code 03h. Status bits 1 and 31..7 always read 0.
- R3: Status bit 5 sets in the cycle after bit 15 of `frame_num` changes value, in either direction. It does not set while that bit holds steady.
- R4: Status bit 3 sets only when `resume_in` rises from low to high while `host_resume` is low. A rise while `host_resume` is high does not set it, and holding `resume_in` high does not set it again.
- R5: A write at code 84h sets every implemented enable bit where the data holds a 1, and leaves bits written with 0 unchanged. A read at 04h returns the enable value.
- R6: A write at code 85h clears every enable bit where the data holds a 1. A read at 05h returns the same enable value as 04h.
- R7: A write at code 83h clears the status bits written with 1. Bits written with 0 keep their value.
- R8: When a hardware event and a status clear of the same bit fall in one cycle, the event wins and the bit stays set.
- R9: `irq` is high exactly when enable bit 31 (master enable) is set and at least one status bit in 6..0 is set together with the enable bit at the same position.
- R10: `halt` is high while status bit 4 is set.
- R11: Each `ev_sched_ovr` pulse adds one to the 2-bit `ovr_count`, which wraps from 3 to 0.
- R12: Enable bits 30..7 and bit 1 are not implemented and read 0 even after ones are written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Always 1, so a command is never stalled |
| cmd_code | input | 8 | Bit 7 selects write; bits 6..0 select the register |
| cmd_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register |
| ev_rhsc | input | 1 | Root hub change pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_sched_ovr | input | 1 | Scheduling overrun pulse |
| ev_sys_err | input | 1 | System error pulse |
| resume_in | input | 1 | Device resume signalling level |
| host_resume | input | 1 | High while the host itself drives resume |
| frame_num | input | 16 | Current frame number |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | Stop processing while an unrecoverable error is pending |
| ovr_count | output | 2 | Scheduling overrun counter |

## Verification
A software clear of a status bit and a hardware event on that same bit can land in one clock cycle. The bench provokes this by driving an `ev_rhsc` pulse in the same cycle as a write at 83h that clears bit 6. It then reads status and expects bit 6 still set. In a second variant, one bit is cleared while an event hits a different bit, and the bench expects only the cleared bit to drop.

// File: rtl/usb_hc_irq_pkg.sv
package usb_hc_irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 7;

  localparam int B_SO    = 0;
  localparam int B_SF    = 2;
  localparam int B_RD    = 3;
  localparam int B_UE    = 4;
  localparam int B_FNO   = 5;
  localparam int B_RHSC  = 6;
  localparam int B_MIE   = 31;

  localparam logic [REG_W-1:0] STATUS_MASK = 32'h0000_007D;
  localparam logic [REG_W-1:0] ENABLE_MASK = 32'h8000_007D;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS  = 7'h03,
    A_ENABLE  = 7'h04,
    A_DISABLE = 7'h05
  } reg_addr_e;
endpackage

// File: rtl/usb_hc_irq_edge.sv
module usb_hc_irq_edge #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               resume_in,
  input  logic               host_resume,
  output logic               fno_evt,
  output logic               rd_evt
);
  logic msb_q, resume_q;
  logic low_unused;

  assign low_unused = ^frame_num[FRAME_W-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msb_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      msb_q    <= frame_num[FRAME_W-1];
      resume_q <= resume_in;
    end
  end

  // toggle of the frame counter top bit in either direction
  assign fno_evt = frame_num[FRAME_W-1] ^ msb_q;
  // device-driven resume start only, not host-driven resume
  assign rd_evt  = resume_in & ~resume_q & ~host_resume;
endmodule

// File: rtl/usb_hc_irq_bits.sv
module usb_hc_irq_bits
  import usb_hc_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = STATUS_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] bits_q
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic b_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          b_q <= 1'b0;
        else if (set_vec[i]) b_q <= 1'b1;   // set wins over clear
        else if (clr_vec[i]) b_q <= 1'b0;
      end
      assign bits_q[i] = b_q;
    end else begin : g_rsvd
      logic unused_in;
      assign unused_in = set_vec[i] ^ clr_vec[i];
      assign bits_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_hc_irq_regs.sv
module usb_hc_irq_regs
  import usb_hc_irq_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [7:0]         cmd_code,
  input  logic [REG_W-1:0]   cmd_wdata,
  output logic [REG_W-1:0]   rd_data,
  input  logic               ev_rhsc,
  input  logic               ev_sof,
  input  logic               ev_sched_ovr,
  input  logic               ev_sys_err,
  input  logic               resume_in,
  input  logic               host_resume,
  input  logic [FRAME_W-1:0] frame_num,
  output logic               irq,
  output logic               halt,
  output logic [CNT_W-1:0]   ovr_count
);
  localparam int SRC_N = 7;

  logic              fno_evt, rd_evt;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  st_set, st_clr, en_set, en_clr;
  logic [REG_W-1:0]  status_q, enable_q;
  logic [CNT_W-1:0]  cnt_q;

  assign cmd_ready = 1'b1;
  assign wr_en     = cmd_valid & cmd_ready & cmd_code[7];
  assign addr      = cmd_code[ADDR_W-1:0];

  usb_hc_irq_edge #(.FRAME_W(FRAME_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num),
    .resume_in(resume_in), .host_resume(host_resume),
    .fno_evt(fno_evt), .rd_evt(rd_evt)
  );

  always_comb begin
    st_set         = '0;
    st_set[B_RHSC] = ev_rhsc;
    st_set[B_FNO]  = fno_evt;
    st_set[B_UE]   = ev_sys_err;
    st_set[B_RD]   = rd_evt;
    st_set[B_SF]   = ev_sof;
    st_set[B_SO]   = ev_sched_ovr;
    st_clr = (wr_en && addr == A_STATUS)  ? cmd_wdata : '0;
    en_set = (wr_en && addr == A_ENABLE)  ? cmd_wdata : '0;
    en_clr = (wr_en && addr == A_DISABLE) ? cmd_wdata : '0;
  end

  usb_hc_irq_bits #(.IMPL_MASK(STATUS_MASK)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(st_set), .clr_vec(st_clr), .bits_q(status_q)
  );

  usb_hc_irq_bits #(.IMPL_MASK(ENABLE_MASK)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr), .bits_q(enable_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (ev_sched_ovr) cnt_q <= cnt_q + 1'b1;
  end
  assign ovr_count = cnt_q;

  always_comb begin
    rd_data = '0;
    if (cmd_valid && !cmd_code[7]) begin
      unique case (addr)
        A_STATUS:           rd_data = status_q;
        A_ENABLE, A_DISABLE: rd_data = enable_q;
        default:            rd_data = '0;
      endcase
    end
  end

  assign irq  = enable_q[B_MIE] & (|(status_q[SRC_N-1:0] & enable_q[SRC_N-1:0]));
  assign halt = status_q[B_UE];
endmodule

// File: rtl/usb_hc_irq_checker.sv
module usb_hc_irq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_rhsc,
  input logic        ev_sof,
  input logic        ev_sys_err,
  input logic        ev_sched_ovr,
  input logic        irq,
  input logic        halt,
  input logic [1:0]  ovr_count,
  input logic [31:0] status_q,
  input logic [31:0] enable_q
);
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ev_rhsc |=> status_q[6]); // R8
  AST_SOF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) ev_sof |=> status_q[2]); // R2
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n) irq |-> enable_q[31]); // R9
  AST_HALT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n) ev_sys_err |=> halt); // R10
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n) ev_sched_ovr |=> ovr_count == $past(ovr_count) + 2'd1); // R11
  AST_RSVD_ENABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) enable_q[30:7] == '0 && !enable_q[1]); // R12
  AST_RSVD_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status_q[31:7] == '0 && !status_q[1]); // R2
endmodule

bind usb_hc_irq_regs usb_hc_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rhsc(ev_rhsc), .ev_sof(ev_sof),
  .ev_sys_err(ev_sys_err), .ev_sched_ovr(ev_sched_ovr), .irq(irq),
  .halt(halt), .ovr_count(ovr_count), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/usb_hc_irq_regs_test.sv
`timescale 1ns/1ps
module usb_hc_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_code = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] rd_data;
  logic ev_rhsc = 0, ev_sof = 0, ev_sched_ovr = 0, ev_sys_err = 0;
  logic resume_in = 0, host_resume = 0;
  logic [15:0] frame_num = '0;
  logic irq, halt;
  logic [1:0] ovr_count;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_cnt = 2'd0;

  always #4 clk = ~clk;

  usb_hc_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
    .ev_rhsc(ev_rhsc), .ev_sof(ev_sof), .ev_sched_ovr(ev_sched_ovr),
    .ev_sys_err(ev_sys_err), .resume_in(resume_in), .host_resume(host_resume),
    .frame_num(frame_num), .irq(irq), .halt(halt), .ovr_count(ovr_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = data;
    tick();
    cmd_valid = 1'b0; cmd_code = '0; cmd_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] data);
    cmd_valid = 1'b1; cmd_code = code;
    #1 data = rd_data;
    cmd_valid = 1'b0; cmd_code = '0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h83, 32'hFFFF_FFFF);
    wr(8'h85, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h03, v); check("R1 status", v, 0);
    rd(8'h04, v); check("R1 enable", v, 0);
    check("R1 irq/halt/cnt", {irq, halt, ovr_count}, 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(ev_rhsc); rd(8'h03, v); check("R2 rhsc bit6", v, 32'h40);
    pulse(ev_sof);  rd(8'h03, v); check("R2 sof bit2", v, 32'h44);
    pulse(ev_sched_ovr); exp_cnt++;
    rd(8'h03, v); check("R2 ovr bit0", v, 32'h45);
    check("R10 halt low before error", halt, 0);
    pulse(ev_sys_err); rd(8'h03, v); check("R2 err bit4", v, 32'h55);
    check("R10 halt high", halt, 1);
    wr(8'h83, 32'h0000_0010); check("R10 halt drops", halt, 0);
    wr(8'h83, 32'h0000_0000); rd(8'h03, v); check("R7 zero write keeps", v, 32'h45);
    wr(8'h83, 32'h0000_0041); rd(8'h03, v); check("R7 partial clear", v, 32'h04);
    clear_all();
  endtask

  task automatic t_frame();
    logic [31:0] v;
    frame_num = 16'h7FFE; tick(); tick();
    rd(8'h03, v); check("R3 steady msb no set", v, 0);
    frame_num = 16'h8000; tick();
    rd(8'h03, v); check("R3 rise sets", v, 32'h20);
    wr(8'h83, 32'h20); frame_num = 16'h8123; tick();
    rd(8'h03, v); check("R3 no set while msb high", v, 0);
    frame_num = 16'h0000; tick();
    rd(8'h03, v); check("R3 fall sets", v, 32'h20);
    clear_all();
  endtask

  task automatic t_resume();
    logic [31:0] v;
    host_resume = 1; resume_in = 1; tick(); tick();
    rd(8'h03, v); check("R4 host resume ignored", v, 0);
    resume_in = 0; host_resume = 0; tick();
    resume_in = 1; tick();
    rd(8'h03, v); check("R4 device resume sets", v, 32'h08);
    wr(8'h83, 32'h08); tick(); tick();
    rd(8'h03, v); check("R4 held level no reset", v, 0);
    resume_in = 0; tick();
    clear_all();
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(8'h84, 32'h0000_0044); wr(8'h84, 32'h0000_0000);
    rd(8'h04, v); check("R5 set and zero keeps", v, 32'h44);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R12 reserved enable zero", v, 32'h8000_007D);
    wr(8'h85, 32'h0000_0041);
    rd(8'h05, v); check("R6 disable clears", v, 32'h8000_003C);
    rd(8'h04, v); check("R6 both codes agree", v, 32'h8000_003C);
    clear_all();
  endtask

  task automatic t_irq();
    wr(8'h84, 32'h0000_0004); pulse(ev_sof);
    check("R9 no master no irq", irq, 0);
    wr(8'h84, 32'h8000_0000); check("R9 irq with master", irq, 1);
    wr(8'h85, 32'h0000_0004); wr(8'h84, 32'h0000_0040);
    check("R9 enable mismatch no irq", irq, 0);
    pulse(ev_rhsc); check("R9 matched irq", irq, 1);
    wr(8'h85, 32'h8000_0000); check("R9 master off", irq, 0);
    clear_all();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(ev_rhsc);
    ev_rhsc = 1; wr(8'h83, 32'h40); ev_rhsc = 0;
    rd(8'h03, v); check("R8 event beats clear", v, 32'h40);
    ev_sof = 1; wr(8'h83, 32'h40); ev_sof = 0;
    rd(8'h03, v); check("R8 other bit cleared", v, 32'h04);
    clear_all();
  endtask

  task automatic t_count();
    for (int i = 0; i < 5; i++) begin
      pulse(ev_sched_ovr); exp_cnt++;
      check("R11 counter", ovr_count, exp_cnt);
    end
    clear_all();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_frame();
    t_resume();
    t_enable();
    t_irq();
    t_collide();
    t_count();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule